// File: doc/BRIEF.md
# Shared-Pool Multi-Queue Occupancy Manager

This block keeps cell counts for 31 logical queues that all draw on one common pool of storage slots. Every queue has its own programmable cell limit. The pool is sized by a parameter and may be smaller than the sum of the limits. A cell can therefore be refused because the pool is exhausted while its own queue still has headroom. The block stores no payload and keeps no pointers. It holds counters, makes the admit or refuse decision for each enqueue and dequeue request, and derives full and empty flags from those counters.

Each cycle one enqueue request and one dequeue request can arrive, each naming a queue index. The verdict on each request comes back as a one-cycle accept or reject pulse in the cycle after the request. A byte-wide register port gives read/write access to the per-queue limits. A write-protect input blocks writes to those limits. The same port returns packed full-flag and empty-flag words, and the top full-flag bit reports the shared pool as exhausted.

Top module: `qpool_occupancy`

## Requirements
- R1: After reset every limit reads 4. The full words at addresses 32..35 read 0x00. The empty words at addresses 36, 37 and 38 read 0xFF, the empty word at 39 reads 0x7F, and `pool_full` is 0.
- R2: A register write to address q (0..30) stores the data byte as queue q's limit when `thr_lock` is 0. When `thr_lock` is 1 the write is dropped and the old limit reads back.
- R3: An enqueue is admitted when three conditions hold: the index is 0..30, the queue's count is below its limit, and the pool has a free slot. On admission `enq_accept` pulses in the following cycle and the queue's count grows by one. An index of 31 is always refused.
- R4: A refused enqueue pulses `enq_reject` in the following cycle and changes no count and no pool state.
- R5: A dequeue is admitted when the queue's count is non-zero. On admission `deq_accept` pulses in the following cycle and the count drops by one. A dequeue from an empty queue pulses `deq_reject` and does not wrap the count.
- R6: An enqueue and a dequeue admitted in the same cycle on the same queue leave that queue's count and the pool's free count unchanged.
- R7: Full word k (address 32+k) bit j is 1 exactly when queue 8k+j holds at least its limit.
- R8: Empty word k (address 36+k) bit j is 1 exactly when queue 8k+j holds no cells. Bit 7 of address 39 always reads 0.
- R9: `pool_full` and bit 7 of address 35 are 1 whenever no pool slot is free, even while individual queues are below their limits.
- R10: Lowering a limit below a queue's current count discards no cells. The queue reports full until its count falls below the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_qid | input | 5 | Queue index of the enqueue request |
| deq_valid | input | 1 | Dequeue request this cycle |
| deq_qid | input | 5 | Queue index of the dequeue request |
| enq_accept | output | 1 | Previous-cycle enqueue was admitted |
| enq_reject | output | 1 | Previous-cycle enqueue was refused |
| deq_accept | output | 1 | Previous-cycle dequeue was admitted |
| deq_reject | output | 1 | Previous-cycle dequeue was refused |
| reg_addr | input | 6 | Register address (limits 0..30, full 32..35, empty 36..39) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| thr_lock | input | 1 | Write-protect for the limit registers |
| pool_full | output | 1 | No free slot left in the shared pool |

## Verification
An enqueue and a dequeue can be decided in the same cycle, either on one queue or on two different queues. Both verdicts are taken from the counts at the start of that cycle. The bench first places one cell in a queue with a limit of 2. It then issues an enqueue and a dequeue on that queue together and expects both to be admitted. It judges the net count by the next two enqueues: exactly one more must be admitted before the full flag rises, and the second must be refused. A second combined request, an enqueue to one queue and a dequeue from an empty queue, must admit the first and refuse the second.

// File: rtl/qpool_pkg.sv
package qpool_pkg;

    localparam int QP_NUM_Q      = 31;
    localparam int QP_CNT_W      = 8;
    localparam int QP_POOL_CELLS = 64;
    localparam int QP_THR_RESET  = 4;

    typedef enum logic [1:0] {
        RGN_LIMIT = 2'd0,
        RGN_FULL  = 2'd1,
        RGN_EMPTY = 2'd2,
        RGN_NONE  = 2'd3
    } reg_region_e;

endpackage

// File: rtl/qpool_thresholds.sv
module qpool_thresholds #(
    parameter int NUM_Q     = 31,
    parameter int CNT_W     = 8,
    parameter int QID_W     = 5,
    parameter int ADDR_W    = 6,
    parameter int THR_RESET = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    input  logic                            lock,
    output logic [NUM_Q-1:0][CNT_W-1:0]     thr
);

    typedef struct packed {
        logic [NUM_Q-1:0][CNT_W-1:0] limit;
    } thr_state_t;

    thr_state_t s_d, s_q;
    logic [QID_W-1:0] sel_d;

    always_comb begin
        s_d   = s_q;
        sel_d = wr_addr[QID_W-1:0];
        if (wr_en && !lock && (int'(wr_addr) < NUM_Q)) begin
            s_d.limit[sel_d] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_Q; i++) begin
                s_q.limit[i] <= CNT_W'(THR_RESET);
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign thr = s_q.limit;

endmodule

// File: rtl/qpool_counters.sv
module qpool_counters #(
    parameter int NUM_Q      = 31,
    parameter int CNT_W      = 8,
    parameter int QID_W      = 5,
    parameter int POOL_CELLS = 64,
    parameter int FREE_W     = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enq_valid,
    input  logic [QID_W-1:0]                enq_qid,
    input  logic                            deq_valid,
    input  logic [QID_W-1:0]                deq_qid,
    input  logic [NUM_Q-1:0][CNT_W-1:0]     thr,
    output logic [NUM_Q-1:0][CNT_W-1:0]     cnt,
    output logic [FREE_W-1:0]               free,
    output logic                            enq_acc,
    output logic                            enq_rej,
    output logic                            deq_acc,
    output logic                            deq_rej
);

    typedef struct packed {
        logic [NUM_Q-1:0][CNT_W-1:0] count;
        logic [FREE_W-1:0]           free_slots;
        logic                        enq_acc;
        logic                        enq_rej;
        logic                        deq_acc;
        logic                        deq_rej;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    logic             enq_in_range, deq_in_range;
    logic [QID_W-1:0] enq_idx, deq_idx;
    logic             enq_ok, deq_ok;

    always_comb begin
        enq_in_range = int'(enq_qid) < NUM_Q;
        deq_in_range = int'(deq_qid) < NUM_Q;
        enq_idx      = enq_in_range ? enq_qid : '0;
        deq_idx      = deq_in_range ? deq_qid : '0;

        // verdicts use start-of-cycle state only
        enq_ok = enq_valid && enq_in_range
              && (s_q.count[enq_idx] < thr[enq_idx])
              && (s_q.free_slots != '0);
        deq_ok = deq_valid && deq_in_range
              && (s_q.count[deq_idx] != '0);

        s_d         = s_q;
        s_d.enq_acc = enq_ok;
        s_d.enq_rej = enq_valid && !enq_ok;
        s_d.deq_acc = deq_ok;
        s_d.deq_rej = deq_valid && !deq_ok;

        for (int i = 0; i < NUM_Q; i++) begin
            if (enq_ok && (enq_idx == QID_W'(i)) && !(deq_ok && (deq_idx == QID_W'(i)))) begin
                s_d.count[i] = s_q.count[i] + CNT_W'(1);
            end else if (deq_ok && (deq_idx == QID_W'(i)) && !(enq_ok && (enq_idx == QID_W'(i)))) begin
                s_d.count[i] = s_q.count[i] - CNT_W'(1);
            end
        end

        unique case ({enq_ok, deq_ok})
            2'b10:   s_d.free_slots = s_q.free_slots - FREE_W'(1);
            2'b01:   s_d.free_slots = s_q.free_slots + FREE_W'(1);
            default: s_d.free_slots = s_q.free_slots;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.count      <= '0;
            s_q.free_slots <= FREE_W'(POOL_CELLS);
            s_q.enq_acc    <= 1'b0;
            s_q.enq_rej    <= 1'b0;
            s_q.deq_acc    <= 1'b0;
            s_q.deq_rej    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt     = s_q.count;
    assign free    = s_q.free_slots;
    assign enq_acc = s_q.enq_acc;
    assign enq_rej = s_q.enq_rej;
    assign deq_acc = s_q.deq_acc;
    assign deq_rej = s_q.deq_rej;

endmodule

// File: rtl/qpool_status.sv
module qpool_status
    import qpool_pkg::*;
#(
    parameter int NUM_Q  = 31,
    parameter int CNT_W  = 8,
    parameter int QID_W  = 5,
    parameter int ADDR_W = 6,
    parameter int FREE_W = 7
) (
    input  logic [NUM_Q-1:0][CNT_W-1:0]     cnt,
    input  logic [NUM_Q-1:0][CNT_W-1:0]     thr,
    input  logic [FREE_W-1:0]               free,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [CNT_W-1:0]                rdata,
    output logic                            pool_empty_slots
);

    localparam int NWORDS     = (NUM_Q + 1 + 7) / 8;
    localparam int FLAG_W     = NWORDS * 8;
    localparam int FULL_BASE  = 1 << QID_W;
    localparam int EMPTY_BASE = FULL_BASE + NWORDS;

    logic [FLAG_W-1:0] full_vec, empty_vec;
    logic              no_slot;

    assign no_slot          = (free == '0);
    assign pool_empty_slots = no_slot;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        if (g < NUM_Q) begin : g_queue
            assign full_vec[g]  = (cnt[g] >= thr[g]);
            assign empty_vec[g] = (cnt[g] == '0);
        end else if (g == FLAG_W - 1) begin : g_global
            assign full_vec[g]  = no_slot;
            assign empty_vec[g] = 1'b0;
        end else begin : g_pad
            assign full_vec[g]  = 1'b0;
            assign empty_vec[g] = 1'b0;
        end
    end

    reg_region_e      region;
    int               word_idx;
    logic [QID_W-1:0] lim_idx;

    always_comb begin
        lim_idx  = rd_addr[QID_W-1:0];
        word_idx = 0;
        region   = RGN_NONE;
        if (int'(rd_addr) < NUM_Q) begin
            region = RGN_LIMIT;
        end else if ((int'(rd_addr) >= FULL_BASE) && (int'(rd_addr) < EMPTY_BASE)) begin
            region   = RGN_FULL;
            word_idx = int'(rd_addr) - FULL_BASE;
        end else if ((int'(rd_addr) >= EMPTY_BASE) && (int'(rd_addr) < EMPTY_BASE + NWORDS)) begin
            region   = RGN_EMPTY;
            word_idx = int'(rd_addr) - EMPTY_BASE;
        end

        unique case (region)
            RGN_LIMIT: rdata = thr[lim_idx];
            RGN_FULL:  rdata = full_vec[word_idx*8 +: 8];
            RGN_EMPTY: rdata = empty_vec[word_idx*8 +: 8];
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/qpool_occupancy.sv
module qpool_occupancy
    import qpool_pkg::*;
#(
    parameter int NUM_Q      = QP_NUM_Q,
    parameter int CNT_W      = QP_CNT_W,
    parameter int POOL_CELLS = QP_POOL_CELLS,
    parameter int THR_RESET  = QP_THR_RESET,
    parameter int QID_W      = 5,
    parameter int ADDR_W     = QID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [QID_W-1:0]  enq_qid,
    input  logic              deq_valid,
    input  logic [QID_W-1:0]  deq_qid,
    output logic              enq_accept,
    output logic              enq_reject,
    output logic              deq_accept,
    output logic              deq_reject,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    input  logic              thr_lock,
    output logic              pool_full
);

    localparam int FREE_W = $clog2(POOL_CELLS + 1);

    logic [NUM_Q-1:0][CNT_W-1:0] q_limit;
    logic [NUM_Q-1:0][CNT_W-1:0] q_count;
    logic [FREE_W-1:0]           free_slots;

    qpool_thresholds #(
        .NUM_Q(NUM_Q), .CNT_W(CNT_W), .QID_W(QID_W),
        .ADDR_W(ADDR_W), .THR_RESET(THR_RESET)
    ) i_thresholds (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .lock    (thr_lock),
        .thr     (q_limit)
    );

    qpool_counters #(
        .NUM_Q(NUM_Q), .CNT_W(CNT_W), .QID_W(QID_W),
        .POOL_CELLS(POOL_CELLS), .FREE_W(FREE_W)
    ) i_counters (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_qid   (enq_qid),
        .deq_valid (deq_valid),
        .deq_qid   (deq_qid),
        .thr       (q_limit),
        .cnt       (q_count),
        .free      (free_slots),
        .enq_acc   (enq_accept),
        .enq_rej   (enq_reject),
        .deq_acc   (deq_accept),
        .deq_rej   (deq_reject)
    );

    qpool_status #(
        .NUM_Q(NUM_Q), .CNT_W(CNT_W), .QID_W(QID_W),
        .ADDR_W(ADDR_W), .FREE_W(FREE_W)
    ) i_status (
        .cnt              (q_count),
        .thr              (q_limit),
        .free             (free_slots),
        .rd_addr          (reg_addr),
        .rdata            (reg_rdata),
        .pool_empty_slots (pool_full)
    );

endmodule

// File: rtl/qpool_occupancy_chk.sv
module qpool_occupancy_chk #(
    parameter int NUM_Q      = 31,
    parameter int CNT_W      = 8,
    parameter int POOL_CELLS = 64,
    parameter int FREE_W     = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        enq_accept,
    input logic                        enq_reject,
    input logic                        deq_accept,
    input logic                        deq_reject,
    input logic                        pool_full,
    input logic [FREE_W-1:0]           free,
    input logic [NUM_Q-1:0][CNT_W-1:0] cnt
);

    int used_total;

    always_comb begin
        used_total = 0;
        for (int i = 0; i < NUM_Q; i++) begin
            used_total = used_total + int'(cnt[i]);
        end
    end

    // R3 / R6: cells held by queues plus free slots always equal the pool
    p_conserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free) + used_total) == POOL_CELLS);

    // R4: a verdict is either accept or reject, never both
    p_enq_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enq_accept, enq_reject}));

    // R4: a refused enqueue with no admitted dequeue leaves the pool untouched
    p_reject_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_reject && !deq_accept) |-> (free == $past(free)));

    // R5: one verdict per dequeue
    p_deq_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({deq_accept, deq_reject}));

    // R5: an admitted dequeue never returns more slots than the pool holds
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deq_accept |-> (int'($past(free)) < POOL_CELLS));

    // R9: no enqueue is admitted while the pool reports no free slot
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enq_accept |-> !$past(pool_full));

endmodule

bind qpool_occupancy qpool_occupancy_chk #(
    .NUM_Q(NUM_Q), .CNT_W(CNT_W), .POOL_CELLS(POOL_CELLS), .FREE_W(FREE_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_accept (enq_accept),
    .enq_reject (enq_reject),
    .deq_accept (deq_accept),
    .deq_reject (deq_reject),
    .pool_full  (pool_full),
    .free       (free_slots),
    .cnt        (q_count)
);

// File: tb/test_qpool_occupancy.sv
`timescale 1ns/1ps
module test_qpool_occupancy;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_valid = 1'b0, deq_valid = 1'b0;
    logic [4:0] enq_qid = '0, deq_qid = '0;
    logic       enq_accept, enq_reject, deq_accept, deq_reject;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       thr_lock = 1'b0;
    logic       pool_full;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    qpool_occupancy i_qpool_occupancy (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_qid(enq_qid),
        .deq_valid(deq_valid), .deq_qid(deq_qid),
        .enq_accept(enq_accept), .enq_reject(enq_reject),
        .deq_accept(deq_accept), .deq_reject(deq_reject),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .thr_lock(thr_lock), .pool_full(pool_full)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one request cycle; verdict pulses sampled after the next rising edge
    task automatic op(input logic ev, input int eq, input logic dv, input int dq,
                      output logic ea, output logic er, output logic da, output logic dr);
        @(negedge clk);
        enq_valid = ev; enq_qid = 5'(eq);
        deq_valid = dv; deq_qid = 5'(dq);
        @(posedge clk); #1;
        ea = enq_accept; er = enq_reject; da = deq_accept; dr = deq_reject;
        enq_valid = 1'b0; deq_valid = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        @(negedge clk);
        reg_addr = 6'(addr);
        #1 data = int'(reg_rdata);
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_addr = 6'(addr); reg_wdata = 8'(data); reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic drain_all();
        logic ea, er, da, dr;
        for (int q = 0; q < 31; q++) begin
            for (int k = 0; k < 8; k++) op(1'b0, 0, 1'b1, q, ea, er, da, dr);
        end
    endtask

    task automatic t_reset();
        int v;
        for (int q = 0; q < 31; q++) begin
            rd(q, v); chk("R1 limit reset", v, 4);
        end
        for (int a = 32; a < 36; a++) begin
            rd(a, v); chk("R1 full word reset", v, 0);
        end
        for (int a = 36; a < 39; a++) begin
            rd(a, v); chk("R1 empty word reset", v, 255);
        end
        rd(39, v); chk("R1 top empty word reset", v, 127);
        chk("R1 pool_full reset", int'(pool_full), 0);
    endtask

    task automatic t_lock();
        int v;
        thr_lock = 1'b0; wr(5, 7);
        rd(5, v); chk("R2 write unlocked", v, 7);
        thr_lock = 1'b1; wr(5, 2);
        rd(5, v); chk("R2 write locked ignored", v, 7);
        thr_lock = 1'b0; wr(5, 4);
        rd(5, v); chk("R2 restore", v, 4);
    endtask

    task automatic t_admit();
        logic ea, er, da, dr;
        int v;
        for (int k = 0; k < 4; k++) begin
            op(1'b1, 0, 1'b0, 0, ea, er, da, dr);
            chk("R3 enqueue accept", int'(ea), 1);
            chk("R3 no reject", int'(er), 0);
        end
        op(1'b1, 0, 1'b0, 0, ea, er, da, dr);
        chk("R4 enqueue over limit accept", int'(ea), 0);
        chk("R4 enqueue over limit reject", int'(er), 1);
        rd(32, v); chk("R7 full bit q0", v, 1);
        rd(36, v); chk("R8 empty bit q0 clear", v, 254);
        op(1'b1, 31, 1'b0, 0, ea, er, da, dr);
        chk("R3 index 31 refused", int'(er), 1);
        rd(32, v); chk("R4 state kept after refusal", v, 1);
    endtask

    task automatic t_deq();
        logic ea, er, da, dr;
        int v;
        for (int k = 0; k < 4; k++) begin
            op(1'b0, 0, 1'b1, 0, ea, er, da, dr);
            chk("R5 dequeue accept (R4 count kept at 4)", int'(da), 1);
        end
        op(1'b0, 0, 1'b1, 0, ea, er, da, dr);
        chk("R5 dequeue empty reject", int'(dr), 1);
        chk("R5 dequeue empty no accept", int'(da), 0);
        rd(36, v); chk("R8 empty bit q0 set", v, 255);
        rd(32, v); chk("R7 full bit q0 clear", v, 0);
        op(1'b1, 0, 1'b0, 0, ea, er, da, dr);
        chk("R5 no wrap after refused dequeue", int'(ea), 1);
        op(1'b0, 0, 1'b1, 0, ea, er, da, dr);
        op(1'b0, 0, 1'b1, 0, ea, er, da, dr);
        chk("R5 count back to zero", int'(dr), 1);
    endtask

    task automatic t_same();
        logic ea, er, da, dr;
        int v;
        wr(3, 2);
        op(1'b1, 3, 1'b0, 0, ea, er, da, dr);
        chk("R6 first cell", int'(ea), 1);
        op(1'b1, 3, 1'b1, 3, ea, er, da, dr);
        chk("R6 same-queue enqueue accept", int'(ea), 1);
        chk("R6 same-queue dequeue accept", int'(da), 1);
        op(1'b1, 3, 1'b0, 0, ea, er, da, dr);
        chk("R6 count unchanged, one more fits", int'(ea), 1);
        rd(32, v); chk("R7 full bit q3 at limit 2", v, 8);
        op(1'b1, 3, 1'b0, 0, ea, er, da, dr);
        chk("R6 third enqueue refused", int'(er), 1);
        op(1'b1, 1, 1'b1, 2, ea, er, da, dr);
        chk("R5 cross enqueue accept", int'(ea), 1);
        chk("R5 cross dequeue empty reject", int'(dr), 1);
        drain_all();
        wr(3, 4);
        rd(36, v); chk("R8 all drained", v, 255);
    endtask

    task automatic t_pool();
        logic ea, er, da, dr;
        int v, acc;
        acc = 0;
        for (int q = 0; q < 16; q++) begin
            for (int k = 0; k < 4; k++) begin
                op(1'b1, q, 1'b0, 0, ea, er, da, dr);
                acc += int'(ea);
            end
        end
        chk("R9 pool accepts 64 cells", acc, 64);
        chk("R9 pool_full port", int'(pool_full), 1);
        rd(35, v); chk("R9 global bit in top full word", (v >> 7) & 1, 1);
        rd(34, v); chk("R9 queue 16 not full", v & 1, 0);
        op(1'b1, 16, 1'b0, 0, ea, er, da, dr);
        chk("R9 enqueue refused on empty pool", int'(er), 1);
        op(1'b0, 0, 1'b1, 0, ea, er, da, dr);
        chk("R9 pool_full clears", int'(pool_full), 0);
        op(1'b1, 16, 1'b0, 0, ea, er, da, dr);
        chk("R9 freed slot reused", int'(ea), 1);
        chk("R9 pool_full again", int'(pool_full), 1);
        drain_all();
        chk("R9 pool_full after drain", int'(pool_full), 0);
    endtask

    task automatic t_lower();
        logic ea, er, da, dr;
        int v;
        for (int k = 0; k < 3; k++) op(1'b1, 20, 1'b0, 0, ea, er, da, dr);
        rd(34, v); chk("R10 q20 below limit", (v >> 4) & 1, 0);
        wr(20, 1);
        rd(34, v); chk("R10 q20 full after lowering", (v >> 4) & 1, 1);
        op(1'b0, 0, 1'b1, 20, ea, er, da, dr);
        chk("R10 cells kept", int'(da), 1);
        rd(34, v); chk("R10 still full at 2", (v >> 4) & 1, 1);
        op(1'b0, 0, 1'b1, 20, ea, er, da, dr);
        rd(34, v); chk("R10 still full at 1", (v >> 4) & 1, 1);
        op(1'b0, 0, 1'b1, 20, ea, er, da, dr);
        chk("R10 third cell kept", int'(da), 1);
        rd(34, v); chk("R10 full clears at 0", (v >> 4) & 1, 0);
        rd(38, v); chk("R8 q20 empty again", (v >> 4) & 1, 1);
        wr(20, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_lock();
        t_admit();
        t_deq();
        t_same();
        t_pool();
        t_lower();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule